// File: doc/BRIEF.md
# Pipelined 16-bit ALU with Operand-Isolated Prefix Adder

This block is a two-stage pipelined arithmetic logic unit for 16-bit operands. A 4-bit opcode selects one of sixteen operations. The eight arithmetic operations run on a parallel-prefix carry adder. The eight bitwise operations take their result from a separate bus that reuses the per-bit AND, OR and XOR terms. The result is delivered with carry-out, zero and signed-overflow flags.

The first stage registers the incoming operation. The operand registers that feed the adder load only for arithmetic operations. During bitwise operations and idle cycles they keep their last contents, so the carry tree does not switch. The bitwise operands have their own registers. The second stage registers the result and the flags.

A valid bit travels with each operation. An operation presented with `in_valid` high before clock edge k appears on the outputs after edge k+1. The adder's raw sum is available on `sum_tap` from the end of stage 1, so the operand isolation can be observed.

Top module: `alu16_isolated`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `result`, `carry_out`, `zero`, `overflow` and `sum_tap` to 0 on the next rising edge.
- R2: An operation sampled with `in_valid`=1 at edge k sets `out_valid`=1 after edge k+1. A cycle with `in_valid`=0 gives `out_valid`=0 one edge later, and `result` and the flags keep their values.
- R3: Arithmetic opcodes give the 16-bit result as follows: 0 = A+B, 1 = A+B+carry_in, 2 = A−B, 3 = A−B−carry_in, 4 = A+1, 5 = A−1, 6 = −A.
- R4: `carry_out` is the unsigned carry of the addition. For the subtract-type opcodes 2, 3, 5, 6 and 7 it is 1 when no borrow occurs. For opcode 3, a `carry_in` of 1 is a borrow of one.
- R5: Bitwise opcodes give: 8 = A AND B, 9 = A OR B, 10 = A XOR B, 11 = NOT A, 12 = NAND, 13 = NOR, 14 = XNOR, 15 = A.
- R6: `zero` is 1 exactly when the 16-bit value the operation produced is all zeros. For opcode 7 this value is the difference A−B.
- R7: For arithmetic opcodes, `overflow` is 1 exactly when the true signed two's-complement result falls outside −32768..32767.
- R8: For bitwise opcodes (8 to 15), `carry_out` and `overflow` are 0.
- R9: Opcode 7 (compare) computes A−B and updates `carry_out`, `zero` and `overflow`, but leaves `result` unchanged.
- R10: `sum_tap` shows the low 16 bits of the most recent valid arithmetic operation's adder result, one edge after that operation is sampled. Across bitwise operations and idle cycles it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation select (0-7 arithmetic, 8-15 bitwise) |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| carry_in | input | 1 | Carry for opcode 1, borrow for opcode 3 |
| out_valid | output | 1 | Result and flags belong to a valid operation |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry / no-borrow flag |
| zero | output | 1 | Registered zero flag |
| overflow | output | 1 | Registered signed-overflow flag |
| sum_tap | output | 16 | Raw adder sum from the isolated operand registers |

## Verification
On every cycle, the assertions check the valid-bit latency, the frozen adder sum during bitwise and idle cycles, the cleared carry and overflow after bitwise operations, the zero flag against the result, and the held result after a compare. The arithmetic and bitwise values, the borrow convention of the subtract forms and the signed-overflow boundaries can only be shown by the bench's reference model. It covers directed corner operands such as 0x7FFF+1, −0x8000 and 0−1, and a long random mix of opcodes and idle cycles.

// File: rtl/alu16_isolated.sv
module alu16_isolated #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero,
  output logic         overflow,
  output logic [W-1:0] sum_tap
);
  localparam int LV = $clog2(W);

  logic [W-1:0] da, db;
  logic         dc;
  logic         s1_valid;
  logic [3:0]   s1_op;
  logic [W-1:0] xa, xb, la, lb;
  logic         xc;

  always_comb begin
    da = op_a;
    db = op_b;
    dc = 1'b0;
    case (opcode[2:0])
      3'd0: dc = 1'b0;
      3'd1: dc = carry_in;
      3'd2: begin db = ~op_b; dc = 1'b1; end
      3'd3: begin db = ~op_b; dc = ~carry_in; end
      3'd4: begin db = '0; dc = 1'b1; end
      3'd5: begin db = '1; dc = 1'b0; end
      3'd6: begin da = '0; db = ~op_a; dc = 1'b1; end
      default: begin db = ~op_b; dc = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      xa <= '0; xb <= '0; xc <= 1'b0;
      la <= '0; lb <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_op <= opcode;
      if (in_valid && !opcode[3]) begin
        xa <= da; xb <= db; xc <= dc;
      end
      if (in_valid && opcode[3]) begin
        la <= op_a; lb <= op_b;
      end
    end
  end

  logic [W-1:0] pr, sum, gk, pk, gn, pn;
  logic [W:0]   cy;
  logic         ovf;

  assign pr = xa ^ xb;

  always_comb begin
    gk = xa & xb;
    gk[0] = gk[0] | (pr[0] & xc);
    pk = pr;
    for (int l = 0; l < LV; l++) begin
      gn = gk;
      pn = pk;
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          gn[i] = gk[i] | (pk[i] & gk[i - (1 << l)]);
          pn[i] = pk[i] & pk[i - (1 << l)];
        end
      end
      gk = gn;
      pk = pn;
    end
  end

  assign cy      = {gk, xc};
  assign sum     = pr ^ cy[W-1:0];
  assign ovf     = cy[W] ^ cy[W-1];
  assign sum_tap = sum;

  logic [W-1:0] l_and, l_or, l_xor, lres;
  assign l_and = la & lb;
  assign l_or  = la | lb;
  assign l_xor = la ^ lb;

  always_comb begin
    case (s1_op[2:0])
      3'd0: lres = l_and;
      3'd1: lres = l_or;
      3'd2: lres = l_xor;
      3'd3: lres = ~la;
      3'd4: lres = ~l_and;
      3'd5: lres = ~l_or;
      3'd6: lres = ~l_xor;
      default: lres = la;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      zero      <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        if (s1_op[3]) begin
          result    <= lres;
          carry_out <= 1'b0;
          overflow  <= 1'b0;
          zero      <= (lres == '0);
        end else begin
          if (s1_op != 4'd7) result <= sum;
          carry_out <= cy[W];
          overflow  <= ovf;
          zero      <= (sum == '0);
        end
      end
    end
  end
endmodule

// File: rtl/alu16_isolated_chk.sv
module alu16_isolated_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   opcode,
  input logic         s1_valid,
  input logic [3:0]   s1_op,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         zero,
  input logic         overflow,
  input logic [W-1:0] sum_tap
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && result == '0 && !carry_out && !zero && !overflow)); // R1
  AST_VALID_PASS: assert property (@(posedge clk) disable iff (rst) s1_valid |=> out_valid); // R2
  AST_BUBBLE_PASS: assert property (@(posedge clk) disable iff (rst) !s1_valid |=> (!out_valid && $stable(result))); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) (s1_valid && s1_op != 4'd7) |=> (zero == (result == '0))); // R6
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (s1_valid && s1_op[3]) |=> (!carry_out && !overflow)); // R8
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst) (s1_valid && s1_op == 4'd7) |=> $stable(result)); // R9
  AST_ADDER_FROZEN: assert property (@(posedge clk) disable iff (rst) (!in_valid || opcode[3]) |=> $stable(sum_tap)); // R10
endmodule

bind alu16_isolated alu16_isolated_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .s1_valid(s1_valid), .s1_op(s1_op), .out_valid(out_valid),
  .result(result), .carry_out(carry_out), .zero(zero),
  .overflow(overflow), .sum_tap(sum_tap)
);

// File: tb/alu16_isolated_bench.sv
`timescale 1ns/1ps
module alu16_isolated_bench;
  logic clk = 1'b0;
  logic rst, in_valid, carry_in;
  logic [3:0] opcode;
  logic [15:0] op_a, op_b;
  logic out_valid, carry_out, zero, overflow;
  logic [15:0] result, sum_tap;

  alu16_isolated u_alu16_isolated (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .zero(zero), .overflow(overflow), .sum_tap(sum_tap)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int p_v, p_op, p_a, p_b, p_c;
  int e_v, e_op, e_res, e_cy, e_ov, e_z, e_tap;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input int op, input int a, input int b, input int ci,
                       output int res, output int cy, output int ov);
    int r, sr, sa, sb;
    sa = (a >= 32768) ? a - 65536 : a;
    sb = (b >= 32768) ? b - 65536 : b;
    r = 0; sr = 0; cy = 0;
    case (op)
      0: begin r = a + b; sr = sa + sb; cy = int'(r > 65535); end
      1: begin r = a + b + ci; sr = sa + sb + ci; cy = int'(r > 65535); end
      2, 7: begin r = a - b; sr = sa - sb; cy = int'(r >= 0); end
      3: begin r = a - b - ci; sr = sa - sb - ci; cy = int'(r >= 0); end
      4: begin r = a + 1; sr = sa + 1; cy = int'(r > 65535); end
      5: begin r = a - 1; sr = sa - 1; cy = int'(r >= 0); end
      6: begin r = -a; sr = -sa; cy = int'(r >= 0); end
      8: r = a & b;
      9: r = a | b;
      10: r = a ^ b;
      11: r = ~a;
      12: r = ~(a & b);
      13: r = ~(a | b);
      14: r = ~(a ^ b);
      default: r = a;
    endcase
    res = r & 65535;
    ov = (op < 8) ? int'(sr > 32767 || sr < -32768) : 0;
  endtask

  task automatic compare_all();
    string rt;
    rt = (e_op >= 8) ? "R5" : (e_op == 7) ? "R9" : "R3";
    chk(out_valid == e_v[0], "R2 out_valid", int'(out_valid), e_v);
    chk(int'(result) == e_res, rt, int'(result), e_res);
    chk(int'(carry_out) == e_cy, (e_op >= 8) ? "R8 carry" : "R4 carry", int'(carry_out), e_cy);
    chk(int'(overflow) == e_ov, (e_op >= 8) ? "R8 overflow" : "R7 overflow", int'(overflow), e_ov);
    chk(int'(zero) == e_z, "R6 zero", int'(zero), e_z);
    chk(int'(sum_tap) == e_tap, "R10 sum_tap", int'(sum_tap), e_tap);
  endtask

  task automatic step(input bit v, input int op, input int a, input int b, input int ci);
    int r, cy, ov;
    in_valid = v; opcode = op[3:0]; op_a = a[15:0]; op_b = b[15:0]; carry_in = ci[0];
    @(posedge clk);
    e_v = p_v;
    if (p_v != 0) begin
      model(p_op, p_a, p_b, p_c, r, cy, ov);
      e_op = p_op;
      if (p_op != 7) e_res = r;
      e_cy = cy; e_ov = ov; e_z = int'(r == 0);
    end
    p_v = int'(v); p_op = op; p_a = a & 65535; p_b = b & 65535; p_c = ci & 1;
    if (v && op < 8) begin
      model(op, a & 65535, b & 65535, ci & 1, r, cy, ov);
      e_tap = r;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int held;
    rst = 1'b1; in_valid = 1'b0; opcode = '0; op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    p_v = 0; p_op = 0; p_a = 0; p_b = 0; p_c = 0;
    e_v = 0; e_op = 0; e_res = 0; e_cy = 0; e_ov = 0; e_z = 0; e_tap = 0;
    // R1: reset state
    chk(!out_valid && result == 0 && !carry_out && !zero && !overflow && sum_tap == 0,
        "R1 reset", int'(result), 0);

    // every opcode directed
    for (int op = 0; op < 16; op++) step(1, op, 16'h1234, 16'h0F0F, 1);
    // R7 overflow and R4 borrow corners
    step(1, 0, 16'h7FFF, 16'h0001, 0);
    step(1, 4, 16'h7FFF, 0, 0);
    step(1, 5, 16'h8000, 0, 0);
    step(1, 6, 16'h8000, 0, 0);
    step(1, 6, 16'h0000, 0, 0);
    step(1, 2, 16'h0000, 16'h0001, 0);
    step(1, 3, 16'h0005, 16'h0005, 1);
    step(1, 3, 16'h0005, 16'h0005, 0);
    step(1, 1, 16'hFFFF, 16'h0000, 1);
    step(1, 0, 16'h8000, 16'h8000, 0);
    // R9 compare: result held, zero from difference
    step(1, 0, 16'h0011, 16'h0022, 0);
    step(1, 7, 16'h0042, 16'h0042, 0);
    step(1, 7, 16'h0001, 16'h0002, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R10 long run of bitwise ops: sum_tap frozen
    step(1, 0, 16'h00AA, 16'h0055, 0);
    held = int'(sum_tap);
    for (int i = 0; i < 20; i++) begin
      step(1, 8 + (i % 8), $urandom & 65535, $urandom & 65535, i & 1);
      chk(int'(sum_tap) == held, "R10 frozen", int'(sum_tap), held);
    end
    // R2 bubbles interleaved
    for (int i = 0; i < 6; i++) step(i % 2 == 0, 9, 16'h00F0, 16'h0F00, 0);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, $urandom % 16, $urandom & 65535, $urandom & 65535, $urandom & 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R1 reset mid-stream
    step(1, 0, 16'h1111, 16'h2222, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid && result == 0 && !carry_out && !zero && !overflow && sum_tap == 0,
        "R1 reset again", int'(result), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule